// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This unit is the hazard controller of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Register reads happen in decode and register writes happen in writeback, so only read-after-write hazards can occur. Write-after-read and write-after-write hazards cannot arise in this pipeline. The unit compares the source register numbers of the instruction in execute with the destination numbers held in the two later pipeline registers. From that comparison it drives the selects for the two ALU operand muxes and for the store-data mux. A dependent ALU instruction can therefore issue right behind its producer with no lost cycle.

Some values cannot be covered by forwarding. A load in execute cannot hand its result to the very next instruction if that instruction needs it as an ALU operand. In that case the unit freezes the program counter and the fetch/decode register for one cycle. It also orders a bubble into the decode/execute register, and the datapath clears every register-write and memory-enable control there. A store whose data comes from the load just ahead of it does not stall. It picks up the loaded value later, when the store reaches the memory stage.

All outputs are combinational functions of the stage fields, gated only by a one-flop reset qualifier. The datapath muxes and the pipeline registers live outside this block.

Top module: `hzu_hazard_unit`

## Requirements
- R1: From a rising edge sampled with rst_n low until the first rising edge sampled with rst_n high, all selects read 2'b00 and mem_sd_fwd, pc_hold, ifid_hold and idex_bubble read 0.
- R2: fwd_a_sel is 2'b01 (take the EX/MEM result) when the EX/MEM stage writes a nonzero register equal to ex_rs1.
- R3: fwd_a_sel is 2'b10 (take the MEM/WB result) when only the MEM/WB stage writes a nonzero register equal to ex_rs1. With no match it is 2'b00 (register file).
- R4: When both later stages write the register named by a source, the EX/MEM value wins and the select is 2'b01.
- R5: A destination register of 0, or a stage write enable that is low, causes neither forwarding nor an interlock.
- R6: fwd_b_sel follows the R2 to R4 rules for ex_rs2, independently of fwd_a_sel.
- R7: fwd_sd_sel follows the same rules for ex_rs2, with one exception. When EX/MEM is a load that writes ex_rs2, fwd_sd_sel is 2'b00, because the loaded value is not yet available.
- R8: mem_sd_fwd is 1 when the instruction in MEM is a store whose data register mem_rs2 is a nonzero register written by the MEM/WB stage.
- R9: pc_hold, ifid_hold and idex_bubble are all 1 when a load in EX writes a nonzero register that the decode instruction uses as an ALU operand, marked by id_rs1_used or id_rs2_used.
- R10: A load in EX whose destination the decode instruction needs only as store data (its use flag is 0) causes no stall.
- R11: A non-load producer in EX never causes a stall, whatever registers decode reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs1_used | input | 1 | Decode instruction feeds id_rs1 to the ALU |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_rs2_used | input | 1 | Decode instruction feeds id_rs2 to the ALU |
| ex_rs1 | input | 5 | First source register in execute |
| ex_rs2 | input | 5 | Second source register in execute (also store data) |
| ex_rd | input | 5 | Destination register in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination register in EX/MEM |
| mem_we | input | 1 | EX/MEM instruction writes a register |
| mem_is_load | input | 1 | EX/MEM instruction is a load |
| mem_is_store | input | 1 | EX/MEM instruction is a store |
| mem_rs2 | input | 5 | Store data register of the EX/MEM instruction |
| wb_rd | input | 5 | Destination register in MEM/WB |
| wb_we | input | 1 | MEM/WB instruction writes a register |
| fwd_a_sel | output | 2 | ALU operand A source: 00 register file, 01 EX/MEM, 10 MEM/WB |
| fwd_b_sel | output | 2 | ALU operand B source, same encoding |
| fwd_sd_sel | output | 2 | Store-data source in execute, same encoding |
| mem_sd_fwd | output | 1 | Memory-stage write data taken from MEM/WB |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a bubble into decode/execute |

## Verification
A wrong comparison or priority shows at a select output in the same cycle as the offending stage fields. In the pipeline it surfaces as a stale operand one cycle later. A missed interlock shows as pc_hold staying low while a load and a dependent reader sit in adjacent stages. A spurious interlock shows as a hold on a non-load producer or on a store-data-only use. Because no state besides the reset qualifier exists, every fault shows immediately at the ports once the triggering fields are applied.

// File: rtl/hzu_pkg.sv
// Shared types for the hazard unit.
// Assumes a two-bit source select understood by the datapath muxes.
package hzu_pkg;

    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_EXMEM = 2'b01,
        SRC_MEMWB = 2'b10
    } src_sel_e;

endpackage

// File: rtl/hzu_src_pick.sv
// Chooses the youngest in-flight producer for one operand register.
// Assumes register 0 is hard-wired zero and never forwarded.
// SKIP_MEM_LOAD: a load in EX/MEM has no data yet, so fall back to the register file.
module hzu_src_pick
    import hzu_pkg::*;
#(
    parameter int RW            = 5,
    parameter bit SKIP_MEM_LOAD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_ld,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_we,
    output src_sel_e      sel
);

    logic mem_hit;
    logic wb_hit;

    // Match each later stage against the source register.
    always_comb begin
        mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
    end

    // Youngest producer first; an unready load masks older producers.
    always_comb begin
        if (mem_hit) begin
            if (SKIP_MEM_LOAD && mem_ld) sel = SRC_RF;
            else                         sel = SRC_EXMEM;
        end else if (wb_hit) begin
            sel = SRC_MEMWB;
        end else begin
            sel = SRC_RF;
        end
    end

    // R2 R5: an EX/MEM select needs a live, nonzero, matching writer there.
    assert_exmem_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_EXMEM) |-> (mem_we && mem_rd != '0 && mem_rd == src));

    // R3 R4: an MEM/WB select needs a matching writer there.
    assert_memwb_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_MEMWB) |-> (wb_we && wb_rd != '0 && wb_rd == src));

    // R4: the MEM/WB select never beats a usable EX/MEM producer.
    assert_young_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_MEMWB) |-> !(mem_we && mem_rd == src && mem_rd != '0 && !(SKIP_MEM_LOAD && mem_ld)));

endmodule

// File: rtl/hzu_load_interlock.sv
// Detects a load in execute whose result the decode instruction needs as an ALU operand.
// Assumes the caller clears the use flags of sources consumed only as store data.
module hzu_load_interlock #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] id_rs1,
    input  logic          id_rs1_used,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_rs2_used,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_ld,
    output logic          stall
);

    logic ld_live;

    // Request a one-cycle freeze when a pending load feeds a decode operand.
    always_comb begin
        ld_live = ex_ld && ex_we && (ex_rd != '0);
        stall   = ld_live && ((id_rs1_used && id_rs1 == ex_rd) ||
                              (id_rs2_used && id_rs2 == ex_rd));
    end

    // R9 R11: only a register-writing load may stall.
    assert_stall_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_ld && ex_we && ex_rd != '0));

    // R10: a stall needs at least one ALU use in decode.
    assert_stall_needs_use_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (id_rs1_used || id_rs2_used));

endmodule

// File: rtl/hzu_hazard_unit.sv
// Hazard control for a five-stage in-order pipeline: forwarding selects
// for ALU operands and store data, plus a one-cycle load-use interlock.
// Assumes reads in decode and writes in writeback, so only RAW hazards exist.
module hzu_hazard_unit
    import hzu_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] id_rs1,
    input  logic          id_rs1_used,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_rs2_used,
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_is_load,
    input  logic          mem_is_store,
    input  logic [RW-1:0] mem_rs2,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_we,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic [1:0]    fwd_sd_sel,
    output logic          mem_sd_fwd,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble
);

    localparam int NSRC = 3;              // operand A, operand B, store data
    localparam int SD_IDX = NSRC - 1;

    logic [RW-1:0] src_reg [NSRC];
    src_sel_e      src_sel [NSRC];
    logic          live_q;
    logic          raw_stall;
    logic          raw_msd;

    // Route the execute-stage sources to their pickers.
    always_comb begin
        src_reg[0] = ex_rs1;
        src_reg[1] = ex_rs2;
        src_reg[2] = ex_rs2;
    end

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_pick
            hzu_src_pick #(
                .RW            (RW),
                .SKIP_MEM_LOAD (g == SD_IDX)
            ) u_pick (
                .clk    (clk),
                .rst_n  (rst_n),
                .src    (src_reg[g]),
                .mem_rd (mem_rd),
                .mem_we (mem_we),
                .mem_ld (mem_is_load),
                .wb_rd  (wb_rd),
                .wb_we  (wb_we),
                .sel    (src_sel[g])
            );
        end
    endgenerate

    hzu_load_interlock #(.RW(RW)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_rs1      (id_rs1),
        .id_rs1_used (id_rs1_used),
        .id_rs2      (id_rs2),
        .id_rs2_used (id_rs2_used),
        .ex_rd       (ex_rd),
        .ex_we       (ex_we),
        .ex_ld       (ex_is_load),
        .stall       (raw_stall)
    );

    // Memory-stage store takes late load data from MEM/WB.
    always_comb begin
        raw_msd = mem_is_store && wb_we && (wb_rd != '0) && (wb_rd == mem_rs2);
    end

    // Reset qualifier: outputs stay idle until a clock edge sees rst_n high.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // Drive the ports, idle while not live.
    always_comb begin
        fwd_a_sel   = live_q ? src_sel[0] : SRC_RF;
        fwd_b_sel   = live_q ? src_sel[1] : SRC_RF;
        fwd_sd_sel  = live_q ? src_sel[SD_IDX] : SRC_RF;
        mem_sd_fwd  = live_q && raw_msd;
        pc_hold     = live_q && raw_stall;
        ifid_hold   = live_q && raw_stall;
        idex_bubble = live_q && raw_stall;
    end

    // R8: late store-data forwarding only for a store in MEM.
    assert_msd_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sd_fwd |-> (mem_is_store && wb_we && wb_rd == mem_rs2));

    // R7: store data never taken from a load still in EX/MEM.
    assert_sd_not_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sd_sel == SRC_EXMEM) |-> !mem_is_load);

    // R9: freeze and bubble always come together.
    assert_freeze_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pc_hold, ifid_hold, idex_bubble}) inside {0, 3});

endmodule

// File: tb/tb_hzu_hazard_unit.sv
module tb_hzu_hazard_unit;

    typedef struct packed {
        logic [4:0] id_rs1; logic id_u1; logic [4:0] id_rs2; logic id_u2;
        logic [4:0] ex_rs1; logic [4:0] ex_rs2; logic [4:0] ex_rd; logic ex_we; logic ex_ld;
        logic [4:0] mem_rd; logic mem_we; logic mem_ld; logic mem_st; logic [4:0] mem_rs2;
        logic [4:0] wb_rd; logic wb_we;
        logic [1:0] e_a; logic [1:0] e_b; logic [1:0] e_sd; logic e_msd; logic e_stall;
    } vec_t;

    localparam int NV = 18;
    // fields: id_rs1 u1 id_rs2 u2 | ex_rs1 ex_rs2 ex_rd we ld | mem_rd we ld st rs2 | wb_rd we | a b sd msd stall
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,  3,4,0,0,0,   3,1,0,0,0,   0,0,   1,0,0,0,0},  // R2
        '{0,0,0,0,  5,4,0,0,0,   6,1,0,0,0,   5,1,   2,0,0,0,0},  // R3
        '{0,0,0,0,  7,4,0,0,0,   7,1,0,0,0,   7,1,   1,0,0,0,0},  // R4
        '{0,0,0,0,  0,0,0,0,0,   0,1,0,0,0,   0,1,   0,0,0,0,0},  // R5 reg 0
        '{0,0,0,0,  9,9,0,0,0,   9,0,0,0,0,   9,0,   0,0,0,0,0},  // R5 we low
        '{0,0,0,0,  2,8,0,0,0,   2,1,0,0,0,   8,1,   1,2,2,0,0},  // R6
        '{0,0,0,0, 11,11,0,0,0,  6,1,0,0,0,  11,1,   2,2,2,0,0},  // R6
        '{0,0,0,0,  1,12,0,0,0, 12,1,1,0,0,  12,1,   0,1,0,0,0},  // R7 load in EX/MEM
        '{0,0,0,0,  1,12,0,0,0, 12,1,0,0,0,   0,0,   0,1,1,0,0},  // R7 ALU in EX/MEM
        '{0,0,0,0,  0,0,0,0,0,   0,0,0,1,13, 13,1,   0,0,0,1,0},  // R8
        '{0,0,0,0,  0,0,0,0,0,   0,0,0,1,13, 13,0,   0,0,0,0,0},  // R8 we low
        '{14,1,0,0, 0,0,14,1,1,  0,0,0,0,0,   0,0,   0,0,0,0,1},  // R9 rs1
        '{1,1,14,1, 0,0,14,1,1,  0,0,0,0,0,   0,0,   0,0,0,0,1},  // R9 rs2
        '{14,0,0,0, 0,0,14,1,1,  0,0,0,0,0,   0,0,   0,0,0,0,0},  // R9 unused source
        '{3,1,15,0, 0,0,15,1,1,  0,0,0,0,0,   0,0,   0,0,0,0,0},  // R10
        '{16,1,16,1,0,0,16,1,0,  0,0,0,0,0,   0,0,   0,0,0,0,0},  // R11
        '{0,1,0,0,  0,0,0,1,1,   0,0,0,0,0,   0,0,   0,0,0,0,0},  // R5 load to reg 0
        '{17,1,0,0, 0,0,17,0,1,  0,0,0,0,0,   0,0,   0,0,0,0,0}   // R5 load we low
    };
    localparam string VREQ [NV] = '{"R2","R3","R4","R5","R5","R6","R6","R7","R7",
                                     "R8","R8","R9","R9","R9","R10","R11","R5","R5"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
    logic id_rs1_used, id_rs2_used, ex_we, ex_is_load, mem_we, mem_is_load, mem_is_store, wb_we;
    logic [1:0] fwd_a_sel, fwd_b_sel, fwd_sd_sel;
    logic mem_sd_fwd, pc_hold, ifid_hold, idex_bubble;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hzu_hazard_unit dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs1_used(id_rs1_used), .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
        .mem_rs2(mem_rs2), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .fwd_sd_sel(fwd_sd_sel),
        .mem_sd_fwd(mem_sd_fwd), .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    task automatic apply(input vec_t v);
        id_rs1 = v.id_rs1; id_rs1_used = v.id_u1; id_rs2 = v.id_rs2; id_rs2_used = v.id_u2;
        ex_rs1 = v.ex_rs1; ex_rs2 = v.ex_rs2; ex_rd = v.ex_rd; ex_we = v.ex_we; ex_is_load = v.ex_ld;
        mem_rd = v.mem_rd; mem_we = v.mem_we; mem_is_load = v.mem_ld; mem_is_store = v.mem_st;
        mem_rs2 = v.mem_rs2; wb_rd = v.wb_rd; wb_we = v.wb_we;
    endtask

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input vec_t v);
        check(req, "fwd_a_sel", {6'd0, fwd_a_sel}, {6'd0, v.e_a});
        check(req, "fwd_b_sel", {6'd0, fwd_b_sel}, {6'd0, v.e_b});
        check(req, "fwd_sd_sel", {6'd0, fwd_sd_sel}, {6'd0, v.e_sd});
        check(req, "mem_sd_fwd", {7'd0, mem_sd_fwd}, {7'd0, v.e_msd});
        check(req, "hold/bubble", {5'd0, pc_hold, ifid_hold, idex_bubble},
              {5'd0, v.e_stall, v.e_stall, v.e_stall});
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        vec_t z;
        z = '0;
        apply(VECS[11]);           // a stall-provoking pattern held through reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_all("R1 in reset", z);
        rst_n = 1'b1;
        #2 check_all("R1 released, before edge", z);
        @(negedge clk);
        check_all("R9 live", VECS[11]);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #2 check_all(VREQ[i], VECS[i]);
        end

        // R1: reset reasserted mid-run idles outputs after the next edge
        @(negedge clk);
        apply(VECS[5]);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1 reasserted", z);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R6 after reset", VECS[5]);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule